// File: doc/BRIEF.md
# Shader Flow-Control Sequencer

This block produces the instruction address stream for a small vector shader core. It follows a program's control flow: plain instructions, no-ops, conditional jumps, jumps gated by a boolean uniform, subroutine calls, if/else regions and counted loops. The instruction memory and the arithmetic datapath sit outside. The block presents a fetch address and gets back, in the same cycle, the decoded flow-control fields of the instruction at that address. The datapath supplies two condition-code bits, and a uniform file supplies the boolean and integer uniforms.

All nesting goes through one hardware stack of frames. Each frame holds an end address, a return address, a repeat count, a per-pass increment and a re-entry address. When the fetch address reaches the end address of the top frame, the sequencer spends one cycle on that frame instead of fetching. It either goes back to the re-entry address or pops the frame and resumes at the return address. In both cases it adds the frame's increment to the loop counter, which it exports to the datapath. It then checks the new address against the new top frame before it fetches.

The fetch side follows valid/ready rules. The address is offered with `fetch_valid`. It is consumed, and the instruction fields are acted on, only in a cycle where `fetch_ready` is also high. While `fetch_ready` is low, the address, the stack and the loop counter all hold, including during unwind cycles. The consumer may raise `fetch_ready` at any time. `done` and `overflow` are plain status levels.

Top module: `shader_flow_seq`

## Requirements
- R1: While not running, a `start` pulse loads `entry_pt` as the fetch address, empties the stack, and clears `loop_ctr`, `done` and `overflow`. From the next cycle the block is running and offers `entry_pt`. `start` is ignored while running.
- R2: An offered address is held unchanged while `fetch_ready` is low, and nothing else advances. Once accepted, op codes 0 (no-op) and 10 to 15 (datapath instructions) move to address+1. All addresses are 12 bits and wrap.
- R3: An accepted op 1 (end) stops the block. From the next cycle `done` is high and `fetch_valid` stays low until the next start.
- R4: Op 2 jumps to `dest` when the condition holds, and otherwise moves to address+1. The condition is built from hx = (`ref_x` == `cc[0]`) and hy = (`ref_y` == `cc[1]`). `cond_mode` selects hx|hy (0), hx&hy (1), hx alone (2) or hy alone (3).
- R5: Op 3 jumps to `dest` when the boolean uniform bit selected by `bool_sel` equals the inverse of `count[0]`, and otherwise moves to address+1.
- R6: Op 4 always calls. A call pushes a frame {end = dest+count, return = address+1, repeat 0, increment 0, re-entry = dest} and continues at `dest`. Reaching the end address later returns to address+1.
- R7: Op 5 calls only when its selected boolean uniform is 1. Op 6 calls only when the R4 condition holds. Otherwise each moves to address+1 with the stack untouched.
- R8: Ops 7 (boolean uniform) and 8 (R4 condition) open a region. When the test is true, the block runs from address+1 up to `dest` and pushes a frame ending at `dest`. When the test is false, it runs from `dest` for `count` instructions. Both cases resume at dest+count.
- R9: Op 9 reads the integer uniform chosen by `int_sel`: 24 bits, bits 7:0 the repeat count, bits 15:8 the loop counter start value, bits 23:16 the increment. It sets `loop_ctr` to the start value and runs the body from address+1 to `dest` inclusive, repeat+1 times, adding the increment at the end of every pass. It then resumes at dest+1.
- R10: Handling a frame at its end address takes one cycle with `fetch_valid` low. The resulting address is checked against the next top frame before any fetch, so several frames ending at the same address unwind one per cycle.
- R11: The stack holds 16 frames. A push while it is full leaves the stack as it was and sets the sticky `overflow` flag. The instruction still moves the address as it would otherwise.
- R12: After reset the block is idle, with `fetch_valid`, `done` and `overflow` low and `loop_ctr` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a program run (accepted only while not running) |
| entry_pt | input | 12 | First fetch address of the run |
| fetch_addr | output | 12 | Address offered to the instruction memory |
| fetch_valid | output | 1 | Address is valid this cycle |
| fetch_ready | input | 1 | Consumer takes the address; low stalls the block |
| op | input | 4 | Decoded flow-control op code of the instruction at `fetch_addr` |
| dest | input | 12 | Destination address field |
| count | input | 8 | Instruction count field |
| ref_x | input | 1 | Reference bit compared with `cc[0]` |
| ref_y | input | 1 | Reference bit compared with `cc[1]` |
| cond_mode | input | 2 | Condition combine mode |
| bool_sel | input | 4 | Boolean uniform index |
| int_sel | input | 2 | Integer uniform index |
| cc | input | 2 | Condition-code bits from the datapath |
| bool_uni | input | 16 | Boolean uniforms |
| int_uni | input | 96 | Four integer uniforms of 24 bits each |
| loop_ctr | output | 8 | Loop counter register |
| done | output | 1 | Program has ended |
| overflow | output | 1 | Sticky stack overflow |

## Verification
Two cases are hard to reach from the ports. One is a push against a full stack: it needs sixteen frames still open at once, which random programs seldom build. The other is several frames that end on the same address and must unwind back to back. A directed program chains seventeen nested calls to force the overflow, and its later returns show whether the stack was left intact. Another directed program nests a call whose return lands exactly on the outer frame's end address. Random programs run under random back-pressure, including empty loop bodies that unwind without fetching, and their address traces are compared with a reference interpreter in the bench.

// File: rtl/shader_flow_pkg.sv
package shader_flow_pkg;
  localparam int PC_W  = 12;
  localparam int CNT_W = 8;
  localparam int RPT_W = 8;
  localparam int IU_W  = 3 * RPT_W;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_END   = 4'd1,
    OP_JMPC  = 4'd2,
    OP_JMPU  = 4'd3,
    OP_CALL  = 4'd4,
    OP_CALLU = 4'd5,
    OP_CALLC = 4'd6,
    OP_IFU   = 4'd7,
    OP_IFC   = 4'd8,
    OP_LOOP  = 4'd9
  } fc_op_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_DONE = 2'd2
  } sq_state_e;

  typedef struct packed {
    logic [PC_W-1:0]  fin;
    logic [PC_W-1:0]  ret;
    logic [RPT_W-1:0] rpt;
    logic [RPT_W-1:0] inc;
    logic [PC_W-1:0]  reent;
  } fc_frame_t;
endpackage

// File: rtl/fc_cond.sv
module fc_cond (
  input  logic       ref_x,
  input  logic       ref_y,
  input  logic [1:0] mode,
  input  logic [1:0] cc,
  output logic       hit
);
  logic hx, hy;

  always_comb begin
    hx = (ref_x == cc[0]);
    hy = (ref_y == cc[1]);
    unique case (mode)
      2'd0:    hit = hx | hy;
      2'd1:    hit = hx & hy;
      2'd2:    hit = hx;
      default: hit = hy;
    endcase
  end
endmodule

// File: rtl/fc_stack.sv
module fc_stack
  import shader_flow_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      push,
  input  fc_frame_t push_frame,
  input  logic      pop,
  input  logic      dec_top,
  output fc_frame_t top_frame,
  output logic      empty,
  output logic      full,
  output logic      ovf
);
  localparam int PTR_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  fc_frame_t        mem [DEPTH];
  logic [PTR_W-1:0] cnt;
  logic [IDX_W-1:0] wr_idx, top_idx;

  assign wr_idx    = cnt[IDX_W-1:0];
  assign top_idx   = IDX_W'(cnt - PTR_W'(1));
  assign empty     = (cnt == '0);
  assign full      = (cnt == PTR_W'(DEPTH));
  assign top_frame = mem[top_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (clr) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (push) begin
      if (full) ovf <= 1'b1;
      else      cnt <= cnt + PTR_W'(1);
    end else if (pop && !empty) begin
      cnt <= cnt - PTR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!clr) begin
      if (push && !full)
        mem[wr_idx] <= push_frame;
      else if (dec_top && !empty)
        mem[top_idx].rpt <= mem[top_idx].rpt - RPT_W'(1);
    end
  end

  a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr) |=> ovf);
  a_r11_full_push_keeps_depth: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !clr) |=> (cnt == $past(cnt)));
  a_r6_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && !clr) |=> (cnt == $past(cnt) + PTR_W'(1)));
  a_r10_single_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push, pop, dec_top}));
endmodule

// File: rtl/shader_flow_seq.sv
module shader_flow_seq
  import shader_flow_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int NUM_BOOL = 16,
  parameter int NUM_INT  = 4,
  parameter int LC_W     = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [PC_W-1:0]           entry_pt,
  output logic [PC_W-1:0]           fetch_addr,
  output logic                      fetch_valid,
  input  logic                      fetch_ready,
  input  logic [3:0]                op,
  input  logic [PC_W-1:0]           dest,
  input  logic [CNT_W-1:0]          count,
  input  logic                      ref_x,
  input  logic                      ref_y,
  input  logic [1:0]                cond_mode,
  input  logic [$clog2(NUM_BOOL)-1:0] bool_sel,
  input  logic [$clog2(NUM_INT)-1:0]  int_sel,
  input  logic [1:0]                cc,
  input  logic [NUM_BOOL-1:0]       bool_uni,
  input  logic [NUM_INT*IU_W-1:0]   int_uni,
  output logic [LC_W-1:0]           loop_ctr,
  output logic                      done,
  output logic                      overflow
);
  sq_state_e       st, st_n;
  logic [PC_W-1:0] pc, pc_n, pc1, dst_cnt;
  logic [LC_W-1:0] lc_n;
  logic            run, at_end, cond_hit, bsel;
  logic            s_clr, s_push, s_pop, s_dec, s_empty, s_full;
  fc_frame_t       s_top, s_new;
  logic [IU_W-1:0] iu;
  logic [RPT_W-1:0] lp_rpt, lp_init, lp_inc;

  fc_cond u_cond (
    .ref_x (ref_x),
    .ref_y (ref_y),
    .mode  (cond_mode),
    .cc    (cc),
    .hit   (cond_hit)
  );

  fc_stack #(.DEPTH(DEPTH)) u_stack (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (s_clr),
    .push       (s_push),
    .push_frame (s_new),
    .pop        (s_pop),
    .dec_top    (s_dec),
    .top_frame  (s_top),
    .empty      (s_empty),
    .full       (s_full),
    .ovf        (overflow)
  );

  assign run         = (st == SQ_RUN);
  assign at_end      = run && !s_empty && (pc == s_top.fin);
  assign fetch_valid = run && !at_end;
  assign fetch_addr  = pc;
  assign done        = (st == SQ_DONE);
  assign pc1         = pc + PC_W'(1);
  assign dst_cnt     = dest + PC_W'(count);
  assign bsel        = bool_uni[bool_sel];
  assign iu          = int_uni[int_sel*IU_W +: IU_W];
  assign lp_rpt      = iu[RPT_W-1:0];
  assign lp_init     = iu[2*RPT_W-1:RPT_W];
  assign lp_inc      = iu[3*RPT_W-1:2*RPT_W];

  always_comb begin
    st_n   = st;
    pc_n   = pc;
    lc_n   = loop_ctr;
    s_clr  = 1'b0;
    s_push = 1'b0;
    s_pop  = 1'b0;
    s_dec  = 1'b0;
    s_new  = '0;
    if (!run) begin
      if (start) begin
        st_n  = SQ_RUN;
        pc_n  = entry_pt;
        lc_n  = '0;
        s_clr = 1'b1;
      end
    end else if (fetch_ready) begin
      if (at_end) begin
        lc_n = loop_ctr + LC_W'(s_top.inc);
        if (s_top.rpt == '0) begin
          s_pop = 1'b1;
          pc_n  = s_top.ret;
        end else begin
          s_dec = 1'b1;
          pc_n  = s_top.reent;
        end
      end else begin
        pc_n = pc1;
        case (fc_op_e'(op))
          OP_END:  st_n = SQ_DONE;
          OP_JMPC: if (cond_hit) pc_n = dest;
          OP_JMPU: if (bsel == !count[0]) pc_n = dest;
          OP_CALL, OP_CALLU, OP_CALLC: begin
            if ((fc_op_e'(op) == OP_CALL) ||
                (fc_op_e'(op) == OP_CALLU && bsel) ||
                (fc_op_e'(op) == OP_CALLC && cond_hit)) begin
              s_push = 1'b1;
              s_new  = '{fin: dst_cnt, ret: pc1, rpt: '0, inc: '0, reent: dest};
              pc_n   = dest;
            end
          end
          OP_IFU, OP_IFC: begin
            s_push = 1'b1;
            if ((fc_op_e'(op) == OP_IFU) ? bsel : cond_hit) begin
              s_new = '{fin: dest, ret: dst_cnt, rpt: '0, inc: '0, reent: pc1};
            end else begin
              s_new = '{fin: dst_cnt, ret: dst_cnt, rpt: '0, inc: '0, reent: dest};
              pc_n  = dest;
            end
          end
          OP_LOOP: begin
            s_push = 1'b1;
            s_new  = '{fin: dest + PC_W'(1), ret: dest + PC_W'(1),
                       rpt: lp_rpt, inc: lp_inc, reent: pc1};
            lc_n   = LC_W'(lp_init);
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SQ_IDLE;
      pc       <= '0;
      loop_ctr <= '0;
    end else begin
      st       <= st_n;
      pc       <= pc_n;
      loop_ctr <= lc_n;
    end
  end

  a_r1_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && start) |=> (fetch_addr == $past(entry_pt)) && fetch_valid | at_end);
  a_r2_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !fetch_ready) |=> ($stable(fetch_addr) && $stable(loop_ctr)));
  a_r3_end_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_ready && op == OP_END) |=> (done && !fetch_valid));
  a_r10_pop_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && fetch_ready && s_top.rpt == '0) |=> (fetch_addr == $past(s_top.ret)));
  a_r9_pass_reenters: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && fetch_ready && s_top.rpt != '0) |=>
      (fetch_addr == $past(s_top.reent) &&
       loop_ctr == $past(loop_ctr) + LC_W'($past(s_top.inc))));
endmodule

// File: tb/shader_flow_seq_bench.sv
module shader_flow_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] entry_pt = '0;
  logic [11:0] fetch_addr;
  logic        fetch_valid;
  logic        fetch_ready = 1'b0;
  logic [3:0]  op;
  logic [11:0] dest;
  logic [7:0]  count;
  logic        ref_x, ref_y;
  logic [1:0]  cond_mode;
  logic [3:0]  bool_sel;
  logic [1:0]  int_sel;
  logic [1:0]  cc = '0;
  logic [15:0] bool_uni = '0;
  logic [95:0] int_uni = '0;
  logic [7:0]  loop_ctr;
  logic        done, overflow;

  always #2 clk = ~clk;

  shader_flow_seq u_shader_flow_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .entry_pt(entry_pt),
    .fetch_addr(fetch_addr), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .op(op), .dest(dest), .count(count), .ref_x(ref_x), .ref_y(ref_y),
    .cond_mode(cond_mode), .bool_sel(bool_sel), .int_sel(int_sel), .cc(cc),
    .bool_uni(bool_uni), .int_uni(int_uni), .loop_ctr(loop_ctr),
    .done(done), .overflow(overflow)
  );

  // program image, addressed by the low 8 bits of the fetch address
  logic [3:0]  p_op  [256];
  logic [11:0] p_dst [256];
  logic [7:0]  p_cnt [256];
  logic        p_rx  [256];
  logic        p_ry  [256];
  logic [1:0]  p_md  [256];
  logic [3:0]  p_bs  [256];
  logic [1:0]  p_is  [256];

  always_comb begin
    op        = p_op [fetch_addr[7:0]];
    dest      = p_dst[fetch_addr[7:0]];
    count     = p_cnt[fetch_addr[7:0]];
    ref_x     = p_rx [fetch_addr[7:0]];
    ref_y     = p_ry [fetch_addr[7:0]];
    cond_mode = p_md [fetch_addr[7:0]];
    bool_sel  = p_bs [fetch_addr[7:0]];
    int_sel   = p_is [fetch_addr[7:0]];
  end

  int n_chk = 0;
  int n_err = 0;
  int exp_tr [1000];
  int exp_len;
  bit exp_done, exp_ovf;
  int exp_lc;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic bit cond_f(input bit rx, input bit ry, input logic [1:0] md, input logic [1:0] c);
    bit hx, hy;
    hx = (rx == c[0]);
    hy = (ry == c[1]);
    case (md)
      2'd0: return hx || hy;
      2'd1: return hx && hy;
      2'd2: return hx;
      default: return hy;
    endcase
  endfunction

  task automatic clr_prog();
    for (int a = 0; a < 256; a++) begin
      p_op[a] = 4'd0; p_dst[a] = '0; p_cnt[a] = '0; p_rx[a] = 1'b0;
      p_ry[a] = 1'b0; p_md[a] = '0; p_bs[a] = '0; p_is[a] = '0;
    end
  endtask

  task automatic put(input int a, input int o, input int d, input int c);
    p_op[a] = 4'(o); p_dst[a] = 12'(d); p_cnt[a] = 8'(c);
  endtask

  // reference interpreter written from the requirements
  task automatic model(input int entry, input int maxt);
    int pc, sp, lc, guard, a, o, d, c, pc1, xyz;
    int fin[16], ret[16], rpt[16], inc[16], ren[16];
    bit cnd, bu, dp;
    int nf, nr, np, ni, ne;
    pc = entry; sp = 0; lc = 0; guard = 0;
    exp_len = 0; exp_done = 0; exp_ovf = 0;
    while (exp_len < maxt && guard < 100000) begin
      guard++;
      if (sp > 0 && pc == fin[sp-1]) begin
        lc = (lc + inc[sp-1]) & 255;
        if (rpt[sp-1] == 0) begin pc = ret[sp-1]; sp--; end
        else begin rpt[sp-1]--; pc = ren[sp-1]; end
        continue;
      end
      exp_tr[exp_len] = pc;
      exp_len++;
      a = pc & 255; o = p_op[a]; d = p_dst[a]; c = p_cnt[a];
      pc1 = (pc + 1) & 4095;
      cnd = cond_f(p_rx[a], p_ry[a], p_md[a], cc);
      bu  = bool_uni[p_bs[a]];
      xyz = int'(int_uni[p_is[a]*24 +: 24]);
      dp = 0; nf = 0; nr = 0; np = 0; ni = 0; ne = 0;
      pc = pc1;
      case (o)
        1: begin exp_done = 1; break; end
        2: if (cnd) pc = d;
        3: if (bu == !c[0]) pc = d;
        4, 5, 6: if (o == 4 || (o == 5 && bu) || (o == 6 && cnd)) begin
          dp = 1; nf = (d + c) & 4095; nr = pc1; ne = d; pc = d;
        end
        7, 8: begin
          dp = 1;
          if ((o == 7) ? bu : cnd) begin nf = d; nr = (d + c) & 4095; ne = pc1; end
          else begin nf = (d + c) & 4095; nr = nf; ne = d; pc = d; end
        end
        9: begin
          dp = 1; nf = (d + 1) & 4095; nr = nf; ne = pc1;
          np = xyz & 255; ni = (xyz >> 16) & 255; lc = (xyz >> 8) & 255;
        end
        default: ;
      endcase
      if (dp) begin
        if (sp == 16) exp_ovf = 1;
        else begin
          fin[sp] = nf; ret[sp] = nr; rpt[sp] = np; inc[sp] = ni; ren[sp] = ne; sp++;
        end
      end
    end
    exp_lc = lc;
  endtask

  task automatic do_reset();
    fetch_ready = 1'b0;
    start = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_prog(input int entry, input int maxt, input bit rnd, input string req);
    int got, idle, bad_a, bad_e;
    bit mism;
    model(entry, maxt);
    do_reset();
    @(negedge clk);
    entry_pt = 12'(entry);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got = 0; idle = 0; mism = 0; bad_a = 0; bad_e = 0;
    while (got < exp_len && idle < 20000) begin
      fetch_ready = rnd ? (($urandom % 4) != 0) : 1'b1;
      #1;
      if (fetch_valid && fetch_ready) begin
        if (int'(fetch_addr) != exp_tr[got] && !mism) begin
          mism = 1; bad_a = int'(fetch_addr); bad_e = exp_tr[got];
        end
        got++;
        idle = 0;
      end else idle++;
      @(negedge clk);
    end
    fetch_ready = 1'b0;
    #1;
    chk(idle < 20000, {req, " progress"}, got, exp_len);
    chk(!mism, {req, " trace"}, bad_a, bad_e);
    chk(done == exp_done, {req, " done"}, done, exp_done);
    chk(overflow == exp_ovf, {req, " overflow"}, overflow, exp_ovf);
    chk(int'(loop_ctr) == exp_lc, {req, " loop_ctr"}, loop_ctr, exp_lc);
  endtask

  initial begin
    #(4 * 190000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    clr_prog();

    // R12: reset state
    do_reset();
    #1;
    chk(!fetch_valid, "R12 valid", fetch_valid, 0);
    chk(!done, "R12 done", done, 0);
    chk(!overflow, "R12 overflow", overflow, 0);
    chk(loop_ctr == 0, "R12 loop_ctr", loop_ctr, 0);

    // R1 start and R2 stall
    put(7, 0, 0, 0); put(8, 0, 0, 0); put(9, 1, 0, 0);
    @(negedge clk);
    entry_pt = 12'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 4; k++) begin
      #1;
      chk(fetch_valid && fetch_addr == 12'd7, "R1 R2 stall hold", fetch_addr, 7);
      @(negedge clk);
    end
    entry_pt = 12'd30; start = 1'b1; fetch_ready = 1'b1;
    @(negedge clk);
    start = 1'b0; fetch_ready = 1'b0;
    #1;
    chk(fetch_addr == 12'd8, "R1 R2 start ignored while running", fetch_addr, 8);

    // R2 R3: straight line with a datapath op, then end
    clr_prog();
    put(5, 0, 0, 0); put(6, 12, 0, 0); put(7, 15, 0, 0); put(8, 1, 0, 0);
    run_prog(5, 100, 1, "R2 R3 straight");

    // R4: every combine mode against every condition code pair
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 4; c++) begin
        clr_prog();
        put(0, 2, 10, 0); p_rx[0] = 1'b1; p_ry[0] = 1'b0; p_md[0] = 2'(m);
        put(1, 1, 0, 0); put(10, 1, 0, 0);
        cc = 2'(c);
        run_prog(0, 10, 0, "R4 jmpc");
      end
    end
    cc = 2'b00;

    // R5: uniform jump polarity
    for (int b = 0; b < 2; b++) begin
      for (int c = 0; c < 2; c++) begin
        clr_prog();
        put(0, 3, 10, c); p_bs[0] = 4'd3;
        put(1, 1, 0, 0); put(10, 1, 0, 0);
        bool_uni = 16'(b << 3);
        run_prog(0, 10, 0, "R5 jmpu");
      end
    end

    // R6: plain call and return
    clr_prog();
    put(0, 4, 20, 3); put(1, 1, 0, 0);
    run_prog(0, 20, 1, "R6 call");

    // R10: inner return lands on the outer end address
    clr_prog();
    put(0, 4, 20, 2); put(1, 1, 0, 0); put(21, 4, 30, 2);
    run_prog(0, 20, 1, "R10 chained unwind");

    // R7: gated calls
    for (int b = 0; b < 2; b++) begin
      clr_prog();
      put(0, 5, 40, 2); p_bs[0] = 4'd9; put(1, 6, 50, 1); p_md[1] = 2'd2; p_rx[1] = 1'b1;
      put(2, 1, 0, 0);
      bool_uni = 16'(b << 9);
      cc = 2'(b);
      run_prog(0, 30, 1, "R7 gated call");
    end

    // R8: if/else regions on both tests and both outcomes
    for (int t = 0; t < 4; t++) begin
      clr_prog();
      put(0, (t < 2) ? 7 : 8, 4, 2); p_bs[0] = 4'd1; p_md[0] = 2'd2; p_rx[0] = 1'b1;
      put(6, 1, 0, 0);
      bool_uni = 16'((t & 1) << 1);
      cc = 2'(t & 1);
      run_prog(0, 30, 1, "R8 region");
    end

    // R9: counted loop, 3 passes, start 5, step 3
    clr_prog();
    put(0, 9, 2, 0); p_is[0] = 2'd2; put(3, 1, 0, 0);
    int_uni = '0;
    int_uni[2*24 +: 24] = {8'd3, 8'd5, 8'd2};
    run_prog(0, 30, 1, "R9 loop");
    chk(exp_lc == 14, "R9 model loop_ctr", exp_lc, 14);

    // R11: seventeen nested calls
    clr_prog();
    for (int i = 0; i < 17; i++) put(i, 4, i + 1, 39 - i);
    run_prog(0, 200, 1, "R11 overflow");
    chk(exp_ovf == 1, "R11 model overflow", exp_ovf, 1);

    // random programs
    for (int r = 0; r < 30; r++) begin
      clr_prog();
      for (int a = 0; a < 64; a++) begin
        int s;
        s = int'($urandom % 20);
        p_op[a]  = (s < 8) ? 4'((s & 1) ? 13 : 0) :
                   (s < 17) ? 4'(s - 6) :
                   (s == 17) ? 4'd1 : 4'd9;
        if (s == 12 || s == 13) p_op[a] = 4'd9;
        p_dst[a] = 12'($urandom % 64);
        p_cnt[a] = 8'($urandom % 8);
        p_rx[a]  = 1'($urandom);
        p_ry[a]  = 1'($urandom);
        p_md[a]  = 2'($urandom);
        p_bs[a]  = 4'($urandom);
        p_is[a]  = 2'($urandom);
      end
      bool_uni = 16'($urandom);
      cc = 2'($urandom);
      for (int u = 0; u < 4; u++)
        int_uni[u*24 +: 24] = {8'($urandom), 8'($urandom), 8'($urandom % 3)};
      run_prog(int'($urandom % 16), 200, 1, "R2 R6 R8 R9 R10 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule